// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves short words over a three-wire synchronous link: a shift clock, a data output and a data input. A word can be 1 to 8 bits long and can go out either most-significant bit first or least-significant bit first. The same setting applies to the word received at the same time. Software-style register accesses set up the port, load the outgoing word, collect the incoming word and read the flags.

The shift clock can come from a free-running prescaler of the system clock. It can also come from an external timer pulse passed through a power-of-two divider. In both of these cases the block drives the clock and is the master. A third setting follows a clock on an input pin. That pin passes through a synchronizer and an edge detector, and the block is then a slave.

Transfers can send only, receive only, or do both. In single mode the port stops after one frame. In continuous mode it runs frames back to back: it reloads from a one-word holding register when sending, and it restarts by itself when only receiving.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register (address 3) reads 0x00, the receive register (address 2) reads 0x00, `sck_out` and `sdo` are high, and `sck_oe` is high.
- R2: A frame has exactly len+1 falling edges of the shift clock, where len is control bits [2:0] (address 0). The shift clock rests high whenever no frame is active.
- R3: With control bit 3 clear, bits go out from bit len down to bit 0. With it set, they go out from bit 0 up to bit len.
- R4: `sdo` changes only together with a falling shift-clock edge, and `sdi` is sampled at the rising edge.
- R5: A received word is right-aligned in the receive register, bits above len read zero, and the word is assembled in the bit order set by control bit 3.
- R6: With clock-config bits [3:2]=0, the shift-clock period is 2, 4, 16 or 64 system clocks for clock-config bits [1:0] = 0, 1, 2, 3.
- R7: With clock-config bits [3:2]=1, each shift-clock half period lasts 1, 2, 4, 8 or 16 `timer_pulse` pulses for clock-config bits [6:4] = 0..4.
- R8: With clock-config bit 3 set, `sck_oe` is low and bits move on the synchronized edges of `sck_in`.
- R9: With continuous (control bit 6) and transmit (bit 4) set, a word written to address 2 before the last bit of the running frame follows it with no idle half period. The port stops when the holding register is empty at the end of a frame.
- R10: With continuous set, receive (bit 5) set and transmit clear, frames repeat without further writes until continuous is cleared, and `sdo` stays high throughout.
- R11: Status bit 1 sets after the final bit of every frame and clears when address 2 is read.
- R12: Status bit 2 (overrun) sets when a receiving frame completes while status bit 1 is still set. Writing 1 to status bit 2 clears it.
- R13: A transmit-only frame leaves the receive register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 clock config, 2 data, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| timer_pulse | input | 1 | One-cycle pulses from an external timer |
| sck_in | input | 1 | Shift clock from outside (slave) |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Shift clock driven as master |
| sck_oe | output | 1 | High when `sck_out` should drive the line |
| sdo | output | 1 | Serial data out |

## Verification
The hardest case to reach is the seamless hand-over between continuous frames. A second word has to be sitting in the holding register at the last rising edge of the running frame, and the fall-to-fall spacing across the frame boundary has to be measured. The bench writes two words back to back at the start of a continuous send, so the second lands while the first frame has barely begun. It then checks that every fall interval, the one across the boundary included, equals the clock period. Overrun is reached by leaving continuous receive running over several frames without reading the data register. The bench then clears continuous while a frame is in flight and checks that the port stops on a frame boundary.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   localparam int REG_W  = 8;
   localparam int LEN_W  = 3;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_CLK  = 2'd1;
   localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

   typedef enum logic [1:0] {
      SRC_PRESC = 2'd0,
      SRC_TIMER = 2'd1,
      SRC_EXT   = 2'd2,
      SRC_EXT_B = 2'd3
   } clk_src_e;

   typedef struct packed {
      logic             cont;
      logic             rx_en;
      logic             tx_en;
      logic             lsb_first;
      logic [LEN_W-1:0] len_m1;
   } ctrl_t;

   typedef struct packed {
      logic [2:0] tdiv;
      clk_src_e   src;
      logic [1:0] psel;
   } clkcfg_t;
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 5,
   parameter int TDIV_W      = 4,
   parameter bit HAS_TIMER   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ssp_pkg::clkcfg_t cfg,
   input  logic            timer_pulse,
   input  logic            sck_in,
   output logic            tick,
   output logic            ext_mode,
   output logic            ext_rise,
   output logic            ext_fall
);
   import ssp_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRESC_W < 5) begin : g_bad_presc
      $error("PRESC_W must be at least 5");
   end
   if (TDIV_W < 4) begin : g_bad_tdiv
      $error("TDIV_W must be at least 4");
   end

   logic [PRESC_W-1:0]   pcnt_q;
   logic [PRESC_W-1:0]   pmask;
   logic                 presc_tick;
   logic                 timer_tick;
   logic [SYNC_STAGES:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
   end

   always_comb begin
      case (cfg.psel)
         2'd0:    pmask = PRESC_W'(0);
         2'd1:    pmask = PRESC_W'(1);
         2'd2:    pmask = PRESC_W'(7);
         default: pmask = PRESC_W'(31);
      endcase
   end
   assign presc_tick = (pcnt_q & pmask) == pmask;

   if (HAS_TIMER) begin : g_timer
      logic [TDIV_W-1:0] tcnt_q;
      logic [TDIV_W-1:0] tmask;
      logic [2:0]        tdiv_eff;
      assign tdiv_eff = (cfg.tdiv > 3'd4) ? 3'd4 : cfg.tdiv;
      assign tmask    = (TDIV_W'(1) << tdiv_eff) - TDIV_W'(1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           tcnt_q <= '0;
         else if (timer_pulse) tcnt_q <= tcnt_q + 1'b1;
      end
      assign timer_tick = timer_pulse && ((tcnt_q & tmask) == tmask);
   end else begin : g_no_timer
      assign timer_tick = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
   assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
   assign ext_mode = cfg.src[1];
   assign tick     = (cfg.src == SRC_PRESC) ? presc_tick : timer_tick;
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
   parameter int REG_W = 8,
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mode,
   input  logic             tick,
   input  logic             ext_rise,
   input  logic             ext_fall,
   input  logic [LEN_W-1:0] len_m1,
   input  logic             lsb_first,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             cont,
   input  logic             hold_full,
   input  logic [REG_W-1:0] hold_data,
   input  logic             sdi,
   output logic             hold_take,
   output logic             busy,
   output logic             sck,
   output logic             sdo,
   output logic             frame_done,
   output logic [REG_W-1:0] rx_word
);
   if (REG_W != (1 << LEN_W)) begin : g_bad_width
      $error("REG_W must equal 2**LEN_W");
   end

   logic             busy_q, sck_q, sdo_q;
   logic [LEN_W-1:0] cnt_q, bit_idx;
   logic [REG_W-1:0] tx_q, rx_q, rx_next;
   logic             fall_ev, rise_ev, last, start, reload;

   assign fall_ev = busy_q &  sck_q & (ext_mode ? ext_fall : tick);
   assign rise_ev = busy_q & ~sck_q & (ext_mode ? ext_rise : tick);
   assign last    = (cnt_q == len_m1);
   assign start   = ~busy_q & hold_full & (tx_en | rx_en);
   assign reload  = rise_ev & last & cont & (tx_en ? hold_full : rx_en);
   assign bit_idx = lsb_first ? cnt_q : (len_m1 - cnt_q);

   always_comb begin
      rx_next = rx_q;
      if (lsb_first) rx_next[cnt_q] = sdi;
      else           rx_next = {rx_q[REG_W-2:0], sdi};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b1;
         sdo_q  <= 1'b1;
         cnt_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         tx_q   <= hold_data;
         rx_q   <= '0;
      end else if (fall_ev) begin
         sck_q <= 1'b0;
         sdo_q <= tx_en ? tx_q[bit_idx] : 1'b1;
      end else if (rise_ev) begin
         sck_q <= 1'b1;
         rx_q  <= rx_next;
         if (last) begin
            cnt_q <= '0;
            if (reload) begin
               tx_q <= hold_data;
               rx_q <= '0;
            end else begin
               busy_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hold_take  = start | (reload & tx_en);
   assign frame_done = rise_ev & last;
   assign rx_word    = rx_next;
   assign busy       = busy_q;
   assign sck        = sck_q;
   assign sdo        = sdo_q;
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port #(
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 5,
   parameter int TDIV_W      = 4,
   parameter bit HAS_TIMER   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       timer_pulse,
   input  logic       sck_in,
   input  logic       sdi,
   output logic       sck_out,
   output logic       sck_oe,
   output logic       sdo
);
   import ssp_pkg::*;

   ctrl_t            ctrl_q;
   clkcfg_t          clkcfg_q;
   logic [REG_W-1:0] hold_q, rx_q, rx_word;
   logic             hold_full_q, done_q, ovr_q;
   logic             tick, ext_mode, ext_rise, ext_fall;
   logic             sh_busy, hold_take, frame_done;
   logic             wr_ctrl, wr_clk, wr_data, wr_stat, rd_data;

   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_clk  = reg_wr && (reg_addr == A_CLK);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign rd_data = reg_rd && (reg_addr == A_DATA);

   ssp_clkgen #(
      .SYNC_STAGES(SYNC_STAGES), .PRESC_W(PRESC_W),
      .TDIV_W(TDIV_W), .HAS_TIMER(HAS_TIMER)
   ) u_clkgen (
      .clk(clk), .rst_n(rst_n), .cfg(clkcfg_q), .timer_pulse(timer_pulse),
      .sck_in(sck_in), .tick(tick), .ext_mode(ext_mode),
      .ext_rise(ext_rise), .ext_fall(ext_fall)
   );

   ssp_shifter #(.REG_W(REG_W), .LEN_W(LEN_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tick(tick),
      .ext_rise(ext_rise), .ext_fall(ext_fall), .len_m1(ctrl_q.len_m1),
      .lsb_first(ctrl_q.lsb_first), .tx_en(ctrl_q.tx_en), .rx_en(ctrl_q.rx_en),
      .cont(ctrl_q.cont), .hold_full(hold_full_q), .hold_data(hold_q), .sdi(sdi),
      .hold_take(hold_take), .busy(sh_busy), .sck(sck_out), .sdo(sdo),
      .frame_done(frame_done), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         clkcfg_q    <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         rx_q        <= '0;
         done_q      <= 1'b0;
         ovr_q       <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q   <= ctrl_t'(reg_wdata[6:0]);
         if (wr_clk)  clkcfg_q <= clkcfg_t'(reg_wdata[6:0]);
         if (wr_data) begin
            hold_q      <= reg_wdata;
            hold_full_q <= 1'b1;
         end else if (hold_take) begin
            hold_full_q <= 1'b0;
         end
         if (frame_done && ctrl_q.rx_en) rx_q <= rx_word;
         if (frame_done)   done_q <= 1'b1;
         else if (rd_data) done_q <= 1'b0;
         if (frame_done && ctrl_q.rx_en && done_q) ovr_q <= 1'b1;
         else if (wr_stat && reg_wdata[2])         ovr_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = {1'b0, ctrl_q};
         A_CLK:   reg_rdata = {1'b0, clkcfg_q};
         A_DATA:  reg_rdata = rx_q;
         default: reg_rdata = {4'b0, hold_full_q, ovr_q, done_q, sh_busy};
      endcase
   end

   assign sck_oe = ~ext_mode;
endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker #(
   parameter int REG_W = 8,
   parameter int LEN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sck,
   input logic             sdo,
   input logic             busy,
   input logic             done,
   input logic             ovr,
   input logic             rx_en,
   input logic [LEN_W-1:0] len_m1,
   input logic [REG_W-1:0] rx
);
   // R4: serial output moves only with a falling shift clock
   p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $fell(sck));

   // R2: shift clock rests high outside a frame
   p_idle_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck);

   // R11: completion flag rises together with a rising shift-clock edge
   p_done_at_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $rose(sck));

   // R12: overrun only when the previous frame was still unread
   p_ovr_after_unread_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(done));

   // R5: received word right-aligned, upper bits zero
   p_rx_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && rx_en) |-> (((rx >> len_m1) >> 1) == '0));
endmodule

bind sync_serial_port ssp_checker #(.REG_W(ssp_pkg::REG_W), .LEN_W(ssp_pkg::LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sck(sck_out), .sdo(sdo), .busy(sh_busy),
   .done(done_q), .ovr(ovr_q), .rx_en(ctrl_q.rx_en), .len_m1(ctrl_q.len_m1),
   .rx(rx_q)
);

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       timer_pulse = 1'b0;
   logic       sck_in = 1'b1;
   logic       sdi;
   logic       sck_out, sck_oe, sdo;

   int   nchk = 0, nerr = 0, cyc = 0, nf = 0;
   int   fall_t [0:63];
   logic [63:0] tx_seen;
   logic [7:0]  drv_word = 8'd0;
   int          drv_len = 1;
   logic        drv_lsb = 1'b0;
   logic        mon_on = 1'b1;
   logic        prev_sck = 1'b1;
   logic        sdi_m = 1'b0, sdi_s = 1'b0;
   logic        finished = 1'b0;

   assign sdi = mon_on ? sdi_m : sdi_s;

   sync_serial_port u_sync_serial_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .timer_pulse(timer_pulse), .sck_in(sck_in), .sdi(sdi),
      .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo)
   );

   always #10 clk = ~clk;

   // monitor: records falls, captures sdo, drives the next sdi bit
   always @(negedge clk) begin
      cyc = cyc + 1;
      timer_pulse = (cyc % 3 == 0);
      if (prev_sck && !sck_out && mon_on) begin
         if (nf < 64) begin
            fall_t[nf]  = cyc;
            tx_seen[nf] = sdo;
         end
         sdi_m = drv_lsb ? drv_word[nf % drv_len] : drv_word[drv_len - 1 - (nf % drv_len)];
         nf = nf + 1;
      end
      prev_sck = sck_out;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         nchk = nchk + 1;
         nerr = nerr + 1;
         $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk = nchk + 1;
      if (!ok) begin
         nerr = nerr + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      s = 8'h01;
      while (s[0] || s[3]) rd(2'd3, s);
   endtask

   function automatic logic exp_bit(input logic [7:0] d, input int len, input logic lsb, input int k);
      return lsb ? d[k] : d[len - 1 - k];
   endfunction

   // one full-duplex single frame with every per-frame check
   task automatic fd_frame(input int len, input logic lsb, input logic [7:0] d, input logic [7:0] r);
      logic [7:0] s, v, mask;
      int bad;
      mask = 8'((9'd1 << len) - 1);
      wr(2'd0, {1'b0, 1'b0, 1'b1, 1'b1, lsb, 3'(len - 1)});
      drv_word = r; drv_len = len; drv_lsb = lsb; nf = 0;
      wr(2'd2, d);
      wait_idle();
      chk(nf == len, "R2 falls per frame", nf, len);
      bad = 0;
      for (int k = 0; k < len; k++) if (tx_seen[k] != exp_bit(d, len, lsb, k)) bad++;
      chk(bad == 0, "R3 transmit bit order", bad, 0);
      rd(2'd3, s);
      chk(s[1] == 1'b1, "R11 done set", int'(s), 2);
      rd(2'd2, v);
      chk(v == (r & mask), "R5 R4 receive aligned", int'(v), int'(r & mask));
      rd(2'd3, s);
      chk(s[1] == 1'b0, "R11 done cleared by read", int'(s), 0);
   endtask

   initial begin
      logic [7:0] s, v, prev_rx;
      int bad, per, n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd3, s); chk(s == 8'h00, "R1 status", int'(s), 0);
      rd(2'd2, v); chk(v == 8'h00, "R1 rx reg", int'(v), 0);
      chk(sck_out == 1'b1 && sdo == 1'b1 && sck_oe == 1'b1, "R1 pins",
          int'({sck_out, sdo, sck_oe}), 7);

      // sweep every length, both orders, several patterns (/2 clock)
      for (int len = 1; len <= 8; len++)
         for (int o = 0; o < 2; o++)
            for (int p = 0; p < 3; p++) begin
               v = 8'h5A + 8'(p * 8'h37) + 8'(len);
               fd_frame(len, o[0], v, {v[3:0], v[7:4]} ^ 8'hC3);
            end
      rd(2'd3, s); chk(s[2] == 1'b0, "R12 no overrun when read each frame", int'(s), 0);

      // R6 prescaler periods
      for (int sel = 0; sel < 4; sel++) begin
         per = (sel == 0) ? 2 : (sel == 1) ? 4 : (sel == 2) ? 16 : 64;
         wr(2'd1, 8'(sel));
         fd_frame(2, 1'b0, 8'h02, 8'h01);
         chk(fall_t[1] - fall_t[0] == per, "R6 prescaled period", fall_t[1] - fall_t[0], per);
      end

      // R7 timer source divided
      for (int dv = 0; dv < 5; dv++) begin
         wr(2'd1, {1'b0, 3'(dv), 2'b01, 2'b00});
         fd_frame(2, 1'b1, 8'h01, 8'h02);
         chk(fall_t[1] - fall_t[0] == 6 * (1 << dv), "R7 timer period",
             fall_t[1] - fall_t[0], 6 * (1 << dv));
      end

      // R8 slave on external clock
      wr(2'd1, 8'h08);
      wr(2'd0, 8'h34);           // full duplex, msb first, 5 bits
      mon_on = 1'b0;
      wr(2'd2, 8'hB3);
      repeat (3) @(negedge clk);
      chk(sck_oe == 1'b0, "R8 clock output disabled", int'(sck_oe), 0);
      bad = 0;
      for (int k = 0; k < 5; k++) begin
         sck_in = 1'b0; sdi_s = exp_bit(8'h0D, 5, 1'b0, k);
         repeat (5) @(negedge clk);
         if (sdo != exp_bit(8'hB3, 5, 1'b0, k)) bad++;
         sck_in = 1'b1;
         repeat (5) @(negedge clk);
      end
      wait_idle();
      chk(bad == 0, "R8 slave transmit bits", bad, 0);
      rd(2'd2, v); chk(v == 8'h0D, "R8 slave receive", int'(v), 13);
      mon_on = 1'b1;

      // R9 continuous transmit, seamless hand-over; R13 rx untouched
      wr(2'd1, 8'h01);
      rd(2'd2, prev_rx);
      wr(2'd0, 8'h5B);           // cont, tx only, lsb first, 4 bits
      nf = 0; drv_len = 4;
      wr(2'd2, 8'h09);
      wr(2'd2, 8'h06);
      wait_idle();
      repeat (40) @(negedge clk);
      chk(nf == 8, "R9 two frames then stop", nf, 8);
      bad = 0;
      for (int k = 0; k < 7; k++) if (fall_t[k + 1] - fall_t[k] != 4) bad++;
      chk(bad == 0, "R9 no idle half period between frames", bad, 0);
      bad = 0;
      for (int k = 0; k < 4; k++) begin
         if (tx_seen[k] != exp_bit(8'h09, 4, 1'b1, k)) bad++;
         if (tx_seen[k + 4] != exp_bit(8'h06, 4, 1'b1, k)) bad++;
      end
      chk(bad == 0, "R9 continuous bit stream", bad, 0);
      rd(2'd2, v); chk(v == prev_rx, "R13 rx unchanged by transmit-only", int'(v), int'(prev_rx));

      // R10 continuous receive-only; R12 overrun
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h62);           // cont, rx only, msb first, 3 bits
      drv_word = 8'h05; drv_len = 3; drv_lsb = 1'b0; nf = 0;
      wr(2'd2, 8'h00);
      while (nf < 9) @(negedge clk);
      wr(2'd0, 8'h22);           // drop continuous
      wait_idle();
      n = nf;
      chk(n >= 9 && n % 3 == 0, "R10 repeats and stops on frame edge", n, 9);
      bad = 0;
      for (int k = 0; k < 9; k++) if (tx_seen[k] != 1'b1) bad++;
      chk(bad == 0, "R10 sdo high in receive-only", bad, 0);
      rd(2'd3, s); chk(s[2] == 1'b1, "R12 overrun set", int'(s), 4);
      rd(2'd2, v); chk(v == 8'h05, "R10 rx word", int'(v), 5);
      wr(2'd3, 8'h04);
      rd(2'd3, s); chk(s[2] == 1'b0, "R12 overrun cleared", int'(s), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule